// File: doc/BRIEF.md
# Digital Offset Cancellation Controller

This block closes the digital feedback loop that removes electrode DC offset in a time-domain ECG front end. On every sample it reads two digitised delay words, one from the positive delay-line branch and one from the negative branch. The two branch delays always add up to the same total, so their difference alone gives the sign and size of the remaining offset. The controller sorts the operating point into one of three regions. It then moves an up/down count by one step, or holds the count where it is.

The count is decoded into a 32-line thermometer switch word that drives the two digital-to-current converters. One count step moves both branch input voltages by one fixed increment of 3.125 mV. A positive offset lengthens the positive-branch delay and shortens the negative-branch delay, and stepping up moves the point back toward balance. Stepping stops once the residual falls inside the tolerance band. The settled count is presented as the digital offset value so that later processing can remove it.

A settled flag marks the end of the cancellation transient. Downstream logic should trust samples only while this flag is high.

Top module: `ofs_cancel_ctrl`

## Requirements
- R1: While rst_n is low, the count is 16, so offset_code = 16, sw_word = 0x0000FFFF and settled = 0.
- R2: A sample is taken only on a clock edge where dp_vld and dn_vld are both high. On any other edge, offset_code, sw_word and settled keep their values.
- R3: On a sample where dp_word − dn_word (unsigned words, exact difference) is greater than thr, the count rises by one at that edge.
- R4: On a sample where dp_word − dn_word is less than −thr, the count falls by one at that edge.
- R5: On a sample where |dp_word − dn_word| ≤ thr (the tolerance region, with inclusive bounds), the count holds.
- R6: The count saturates at 0 and at 32. A step up at 32 or a step down at 0 leaves it unchanged.
- R7: sw_word is a thermometer code of the count N: bit i is 1 exactly when i < N.
- R8: offset_code always equals the current count, from 0 to 32.
- R9: settled rises at the edge of the settle_len-th consecutive tolerance-region sample. Clock edges without a sample do not break the run. A settle_len of 0 acts as 1.
- R10: A sample outside the tolerance region clears settled and restarts the run. The count steps at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| dp_word | input | 12 | Digitised positive-branch delay |
| dp_vld | input | 1 | dp_word is valid this cycle |
| dn_word | input | 12 | Digitised negative-branch delay |
| dn_vld | input | 1 | dn_word is valid this cycle |
| thr | input | 12 | Half-width of the tolerance band in delay-word units |
| settle_len | input | 8 | Consecutive tolerance-region samples needed to settle |
| sw_word | output | 32 | Thermometer switch word to the current converters |
| offset_code | output | 6 | Current correction count, the digital offset value |
| settled | output | 1 | Cancellation transient has ended |

## Verification
Two things can happen at the same edge: a settled loop drops out of lock, and the search resumes stepping. The stimulus table first drives three in-band samples to raise settled. It then applies a sample with a large negative difference. The check expects settled to be low and the count to be one lower after that single edge. A second pairing comes from saturation. With the count at 32 or 0, further samples in the same direction must hold the count and still keep the settle run cleared.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [1:0] {
    REG_HOLD = 2'd0,
    REG_UP   = 2'd1,
    REG_DN   = 2'd2
  } region_t;
endpackage

// File: rtl/ofs_region_cls.sv
module ofs_region_cls
  import ofs_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic [DW-1:0] dp_word,
  input  logic [DW-1:0] dn_word,
  input  logic [DW-1:0] thr,
  output region_t       region
);
  localparam int XW = DW + 1;

  logic signed [XW-1:0] diff;
  logic signed [XW-1:0] thr_pos;
  logic signed [XW-1:0] thr_neg;

  always_comb begin
    diff    = $signed({1'b0, dp_word}) - $signed({1'b0, dn_word});
    thr_pos = $signed({1'b0, thr});
    thr_neg = -thr_pos;
    if (diff > thr_pos)      region = REG_UP;
    else if (diff < thr_neg) region = REG_DN;
    else                     region = REG_HOLD;
  end
endmodule

// File: rtl/ofs_step_cnt.sv
module ofs_step_cnt
  import ofs_pkg::*;
#(
  parameter int NSW = 32,
  parameter int CW  = $clog2(NSW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  region_t       region,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL = CW'(NSW);
  localparam logic [CW-1:0] MID  = CW'(NSW / 2);

  logic          cnt_en;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_en  = 1'b0;
    cnt_nxt = count;
    if (sample) begin
      case (region)
        REG_UP: if (count != FULL) begin
          cnt_en  = 1'b1;
          cnt_nxt = count + CW'(1);
        end
        REG_DN: if (count != '0) begin
          cnt_en  = 1'b1;
          cnt_nxt = count - CW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= MID;
    else if (cnt_en) count <= cnt_nxt;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL); // R6
  AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && region == REG_UP && count != FULL) |=> count == $past(count) + CW'(1)); // R3
  AST_CNT_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && region == REG_DN && count != '0) |=> count == $past(count) - CW'(1)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && region == REG_HOLD) |=> $stable(count)); // R5
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(count)); // R2
endmodule

// File: rtl/ofs_therm_dec.sv
module ofs_therm_dec #(
  parameter int NSW = 32,
  parameter int CW  = $clog2(NSW + 1)
) (
  input  logic [CW-1:0]  count,
  output logic [NSW-1:0] sw_word
);
  for (genvar i = 0; i < NSW; i++) begin : g_line
    assign sw_word[i] = (count > CW'(i));
  end
endmodule

// File: rtl/ofs_settle_mon.sv
module ofs_settle_mon #(
  parameter int SLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample,
  input  logic           in_band,
  input  logic [SLW-1:0] settle_len,
  output logic           settled
);
  logic [SLW-1:0] run;
  logic [SLW-1:0] run_nxt;
  logic           set_nxt;

  always_comb begin
    run_nxt = '0;
    if (in_band) run_nxt = (run == '1) ? run : run + SLW'(1);
    set_nxt = in_band && (run_nxt >= settle_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= '0;
      settled <= 1'b0;
    end else if (sample) begin
      run     <= run_nxt;
      settled <= set_nxt;
    end
  end

  AST_SETTLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !in_band) |=> !settled); // R10
  AST_SETTLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> $past(sample && in_band)); // R9
  AST_SETTLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(settled)); // R2
endmodule

// File: rtl/ofs_cancel_ctrl.sv
module ofs_cancel_ctrl
  import ofs_pkg::*;
#(
  parameter int DW  = 12,
  parameter int NSW = 32,
  parameter int SLW = 8,
  parameter int CW  = $clog2(NSW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  dp_word,
  input  logic           dp_vld,
  input  logic [DW-1:0]  dn_word,
  input  logic           dn_vld,
  input  logic [DW-1:0]  thr,
  input  logic [SLW-1:0] settle_len,
  output logic [NSW-1:0] sw_word,
  output logic [CW-1:0]  offset_code,
  output logic           settled
);
  region_t       region;
  logic          sample;
  logic [CW-1:0] count;

  assign sample      = dp_vld && dn_vld;
  assign offset_code = count;

  ofs_region_cls #(.DW(DW)) u_cls (
    .dp_word (dp_word),
    .dn_word (dn_word),
    .thr     (thr),
    .region  (region)
  );

  ofs_step_cnt #(.NSW(NSW), .CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (sample),
    .region (region),
    .count  (count)
  );

  ofs_therm_dec #(.NSW(NSW), .CW(CW)) u_dec (
    .count   (count),
    .sw_word (sw_word)
  );

  ofs_settle_mon #(.SLW(SLW)) u_set (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample     (sample),
    .in_band    (region == REG_HOLD),
    .settle_len (settle_len),
    .settled    (settled)
  );

  AST_THERM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sw_word) == 32'(offset_code)); // R7
  AST_THERM_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_word & (sw_word + NSW'(1))) == '0); // R7
endmodule

// File: tb/sim_ofs_cancel_ctrl.sv
`timescale 1ns/1ps
module sim_ofs_cancel_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] dp_word, dn_word, thr;
  logic        dp_vld, dn_vld;
  logic [7:0]  settle_len;
  logic [31:0] sw_word;
  logic [5:0]  offset_code;
  logic        settled;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ofs_cancel_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .dp_word(dp_word), .dp_vld(dp_vld),
    .dn_word(dn_word), .dn_vld(dn_vld),
    .thr(thr), .settle_len(settle_len),
    .sw_word(sw_word), .offset_code(offset_code), .settled(settled)
  );

  localparam int NV = 12;
  localparam int V_DP [NV] = '{100, 100, 100,  90, 50, 50, 40, 40, 45, 2000,    0, 4095};
  localparam int V_DN [NV] = '{ 90,  95,  96,  94, 50, 52, 60, 45, 45,    0, 4095,    0};
  localparam int V_N  [NV] = '{ 17,  18,  18,  18, 18, 18, 17, 16, 16,   17,   16,   17};
  localparam int V_S  [NV] = '{  0,   0,   0,   0,  1,  1,  0,  0,  0,    0,    0,    0};

  function automatic logic [31:0] therm(int n);
    logic [31:0] w = '0;
    for (int i = 0; i < 32; i++) if (i < n) w[i] = 1'b1;
    return w;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(string req, int n, int s);
    chk({req, " count"}, offset_code, n);
    chk({req, " switch word"}, sw_word, therm(n));
    chk({req, " settled"}, settled, s);
  endtask

  task automatic take(int p, int n);
    @(negedge clk);
    dp_word = 12'(p); dn_word = 12'(n);
    dp_vld = 1'b1; dn_vld = 1'b1;
    @(negedge clk);
    dp_vld = 1'b0; dn_vld = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dp_vld = 1'b0; dn_vld = 1'b0;
    dp_word = '0; dn_word = '0; thr = 12'd4; settle_len = 8'd3;
    repeat (3) @(negedge clk);
    chk_state("R1 reset", 16, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R7 R8 R9 R10 via table
    for (int k = 0; k < NV; k++) begin
      take(V_DP[k], V_DN[k]);
      chk_state($sformatf("R3/R4/R5/R9/R10 row%0d", k), V_N[k], V_S[k]);
    end

    // R2: one valid alone does not sample
    @(negedge clk);
    dp_word = 12'd4000; dn_word = 12'd0; dp_vld = 1'b1; dn_vld = 1'b0;
    @(negedge clk);
    chk_state("R2 dp only", 17, 0);
    dp_vld = 1'b0; dn_vld = 1'b1;
    @(negedge clk);
    chk_state("R2 dn only", 17, 0);
    dn_vld = 1'b0;

    // R6 upper saturation
    for (int k = 0; k < 20; k++) take(500, 0);
    chk_state("R6 top", 32, 0);
    // R6 lower saturation
    for (int k = 0; k < 40; k++) take(0, 500);
    chk_state("R6 bottom", 0, 0);

    // R9 run survives idle edges
    take(10, 10);
    @(negedge clk);
    take(10, 12);
    chk_state("R9 two of three", 0, 0);
    @(negedge clk);
    take(12, 8);
    chk_state("R9 third in band", 0, 1);

    // R9 zero length acts as one
    settle_len = 8'd0;
    take(30, 0);
    chk_state("R10 step out", 1, 0);
    take(7, 7);
    chk_state("R9 length zero", 1, 1);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_state("R1 reset again", 16, 0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule